// File: doc/BRIEF.md
# Paging Receiver Sync Acquisition Controller

This block is the mode machine that decides when the radio front end of a pager is powered and which pattern the decoder is hunting for. It keeps the receiver's position inside the 544-bit batch: one 32-bit sync codeword followed by eight frames of two codewords each, 17 codewords in all. It advances that position on a one-cycle bit-period tick and moves between six acquisition and tracking modes. The inputs are detection pulses from an external correlator: preamble seen, sync word seen, enabled user address seen, uncorrectable codeword, and call finished. Each pulse is valid only on a tick cycle.

The receiver enable is duty-cycled by mode. It stays on continuously while searching after switch-on or during preamble. In tracking it covers only the sync slot and the enabled address frames, and it stays on for a whole call. In fade recovery it opens a widened window around the expected sync position. In carrier-off it is on for one codeword out of every eighteen. The oscillator enable rises a programmable number of ticks ahead of each receiver window, and both drop together when the window closes. The current mode is reported as a 3-bit code. A one-clock pulse marks a call dropped because batch sync was lost. The correlator and the message storage sit outside this block.

Top module: `sacq_ctrl`

## Requirements
- R1: The block is ON when on_pin or on_reg is 1. One clock after both are 0, mode is OFF and rx_en and osc_en are 0. One clock after an enable appears while in OFF, mode is switch-on.
- R2: In switch-on, rx_en is 1. An accepted sync goes to data receive and an accepted preamble goes to preamble receive. With neither, the 1632nd tick (3 batches) goes to carrier-off.
- R3: In preamble receive, rx_en is 1 and sync goes to data receive. Each preamble restarts a 544-tick window, and the tick that ends that window with no preamble goes to carrier-off.
- R4: A sync accepted in switch-on, preamble receive, fade recovery or carrier-off realigns the position so that this tick ends the sync codeword. The next position is codeword 1, bit 0 (position 32).
- R5: In data receive and data fail, rx_en is 1 during codeword 0 and during codewords 2f+1 and 2f+2 when frame_mask bit f is 1. It is also 1 at every position while a call is active. addr_hit starts a call and call_done ends it.
- R6: In data receive, the tick at the last bit of codeword 0 (position 31) is the sync test. If no call is active and sync_hit is 0, the mode goes to data fail. If a call is active, the test is skipped and the mode stays data receive.
- R7: In data receive, uncorr_hit goes to data fail while a call is active. It has no effect when no call is active.
- R8: In data fail, the next position-31 tick with sync_hit returns to data receive. Without sync_hit, that tick goes to fade recovery, clears the call and pulses call_term for exactly one clock.
- R9: In fade recovery, rx_en is 1 only from position 536 through 543 and from position 0 through 39, a window of ±8 bits around the sync slot. Detections outside that window are ignored. Sync goes to data receive, preamble goes to preamble receive, and the 8160th tick (15 batches) goes to carrier-off.
- R10: Carrier-off counts a 576-tick scan cycle starting at 0 on entry, and rx_en is 1 during the first 32 ticks of each cycle. Sync or preamble detected in that window goes to data receive or preamble receive; outside it they are ignored.
- R11: osc_en is 1 whenever the receiver window is open now, or will be open lead_ticks ticks ahead under the current mode. osc_en therefore rises lead_ticks ticks before rx_en and falls with it.
- R12: mode encodes OFF=0, switch-on=1, preamble receive=2, data receive=3, data fail=4, fade recovery=5, carrier-off=6. The value 7 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_pin | input | 1 | Direct ON control |
| on_reg | input | 1 | Control-register ON bit |
| bit_tick | input | 1 | One-cycle pulse per received bit period |
| pre_hit | input | 1 | Preamble detected (valid with bit_tick) |
| sync_hit | input | 1 | Sync word detected (valid with bit_tick) |
| addr_hit | input | 1 | Enabled user address detected (valid with bit_tick) |
| call_done | input | 1 | Call termination criteria met (valid with bit_tick) |
| uncorr_hit | input | 1 | Uncorrectable message codeword (valid with bit_tick) |
| frame_mask | input | FRAMES | Enabled address frames, bit f for frame f |
| lead_ticks | input | LEAD_W | Oscillator lead time in ticks |
| rx_en | output | 1 | Receiver enable |
| osc_en | output | 1 | Receiver oscillator enable |
| mode | output | 3 | Current mode code |
| call_term | output | 1 | One-clock pulse when a call is lost |

## Verification
Every mode, position and timer change takes effect at the clock edge that samples the tick, so the new mode and the enables decoded from it are visible one clock after the tick is driven. call_term is high for exactly that one clock. An enable change moves mode to OFF or switch-on one clock later, even without a tick. The bench keeps a behavioural model that advances at the same edge. It compares all four outputs 2 ns after every rising edge. Directed checks are made at the falling edge that follows each tick. Timeout checks count ticks from the mode's entry tick to the first tick on which the mode has changed.

// File: rtl/sacq_pkg.sv
package sacq_pkg;
  typedef enum logic [2:0] {
    MD_OFF    = 3'd0,
    MD_SWON   = 3'd1,
    MD_PRE    = 3'd2,
    MD_DATA   = 3'd3,
    MD_FAIL   = 3'd4,
    MD_FADE   = 3'd5,
    MD_CAROFF = 3'd6
  } sacq_mode_e;
endpackage

// File: rtl/sacq_timebase.sv
module sacq_timebase #(
  parameter int CW_BITS    = 32,
  parameter int BATCH_BITS = 544,
  parameter int LIN_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             realign,
  output logic [LIN_W-1:0] lin
);
  localparam logic [LIN_W-1:0] LAST  = LIN_W'(BATCH_BITS - 1);
  localparam logic [LIN_W-1:0] AFTER = LIN_W'(CW_BITS);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lin <= '0;
    end else if (tick) begin
      if (realign)        lin <= AFTER;
      else if (lin == LAST) lin <= '0;
      else                lin <= lin + 1'b1;
    end
  end
endmodule

// File: rtl/sacq_window.sv
module sacq_window
  import sacq_pkg::*;
#(
  parameter int CW_BITS      = 32,
  parameter int CW_PER_BATCH = 17,
  parameter int FRAMES       = 8,
  parameter int FADE_TOL     = 8,
  parameter int SCAN_BITS    = 576,
  parameter int LIN_W        = 10,
  parameter int WIN_W        = 13,
  parameter int LEAD_W       = 4
) (
  input  sacq_mode_e        mode,
  input  logic [LIN_W-1:0]  lin,
  input  logic [WIN_W-1:0]  win,
  input  logic              call_act,
  input  logic [FRAMES-1:0] frame_mask,
  input  logic [LEAD_W-1:0] lead,
  output logic              rx_need,
  output logic              osc_need
);
  localparam int BATCH_BITS = CW_BITS * CW_PER_BATCH;
  localparam int CW_W       = $clog2(CW_PER_BATCH);
  localparam logic [LIN_W-1:0] L_CW     = LIN_W'(CW_BITS);
  localparam logic [LIN_W-1:0] L_LATE   = LIN_W'(CW_BITS + FADE_TOL);
  localparam logic [LIN_W-1:0] L_EARLY  = LIN_W'(BATCH_BITS - FADE_TOL);
  localparam logic [LIN_W:0]   L_BATCH  = (LIN_W+1)'(BATCH_BITS);
  localparam logic [WIN_W:0]   W_SCAN   = (WIN_W+1)'(SCAN_BITS);
  localparam logic [WIN_W-1:0] W_CW     = WIN_W'(CW_BITS);

  logic [LIN_W:0]   lin_sum;
  logic [WIN_W:0]   win_sum;
  logic [LIN_W-1:0] lin_fut;
  logic [WIN_W-1:0] win_fut;
  logic [LIN_W-1:0] cwf_cur, cwf_fut;
  logic [CW_W-1:0]  cw_cur, cw_fut;
  logic [FRAMES-1:0] hit_cur, hit_fut;

  always_comb begin
    lin_sum = {1'b0, lin} + (LIN_W+1)'(lead);
    win_sum = {1'b0, win} + (WIN_W+1)'(lead);
    lin_fut = (lin_sum >= L_BATCH) ? LIN_W'(lin_sum - L_BATCH) : lin_sum[LIN_W-1:0];
    win_fut = (win_sum >= W_SCAN)  ? WIN_W'(win_sum - W_SCAN)  : win_sum[WIN_W-1:0];
    cwf_cur = lin / L_CW;
    cwf_fut = lin_fut / L_CW;
    cw_cur  = cwf_cur[CW_W-1:0];
    cw_fut  = cwf_fut[CW_W-1:0];
  end

  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    assign hit_cur[f] = frame_mask[f] &&
      ((cw_cur == CW_W'(2*f+1)) || (cw_cur == CW_W'(2*f+2)));
    assign hit_fut[f] = frame_mask[f] &&
      ((cw_fut == CW_W'(2*f+1)) || (cw_fut == CW_W'(2*f+2)));
  end

  function automatic logic need_at(input sacq_mode_e m, input logic [LIN_W-1:0] l,
                                   input logic [WIN_W-1:0] w, input logic fh,
                                   input logic call);
    case (m)
      MD_SWON, MD_PRE:  need_at = 1'b1;
      MD_DATA, MD_FAIL: need_at = call || (l < L_CW) || fh;
      MD_FADE:          need_at = (l >= L_EARLY) || (l < L_LATE);
      MD_CAROFF:        need_at = (w < W_CW);
      default:          need_at = 1'b0;
    endcase
  endfunction

  always_comb begin
    rx_need  = need_at(mode, lin, win, |hit_cur, call_act);
    osc_need = rx_need || need_at(mode, lin_fut, win_fut, |hit_fut, call_act);
  end
endmodule

// File: rtl/sacq_fsm.sv
module sacq_fsm
  import sacq_pkg::*;
#(
  parameter int CW_BITS   = 32,
  parameter int SWON_LIM  = 1632,
  parameter int PRE_LIM   = 544,
  parameter int FADE_LIM  = 8160,
  parameter int SCAN_BITS = 576,
  parameter int LIN_W     = 10,
  parameter int WIN_W     = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on,
  input  logic             tick,
  input  logic             sync_hit,
  input  logic             pre_hit,
  input  logic             addr_hit,
  input  logic             call_done,
  input  logic             uncorr_hit,
  input  logic             rx_need,
  input  logic [LIN_W-1:0] lin,
  output sacq_mode_e       mode,
  output logic [WIN_W-1:0] win,
  output logic             call_act,
  output logic             call_term,
  output logic             realign
);
  localparam logic [WIN_W-1:0] W_SWON = WIN_W'(SWON_LIM - 1);
  localparam logic [WIN_W-1:0] W_PRE  = WIN_W'(PRE_LIM - 1);
  localparam logic [WIN_W-1:0] W_FADE = WIN_W'(FADE_LIM - 1);
  localparam logic [WIN_W-1:0] W_SCAN = WIN_W'(SCAN_BITS - 1);
  localparam logic [LIN_W-1:0] L_SLOT = LIN_W'(CW_BITS - 1);

  logic acq, slot_end, call_nx;

  always_comb begin
    acq      = (mode == MD_SWON) || (mode == MD_PRE) ||
               (((mode == MD_FADE) || (mode == MD_CAROFF)) && rx_need);
    realign  = on && tick && acq && sync_hit;
    slot_end = (lin == L_SLOT);
    call_nx  = addr_hit ? 1'b1 : (call_done ? 1'b0 : call_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MD_OFF;
      win       <= '0;
      call_act  <= 1'b0;
      call_term <= 1'b0;
    end else begin
      call_term <= 1'b0;
      if (!on) begin
        mode     <= MD_OFF;
        win      <= '0;
        call_act <= 1'b0;
      end else if (mode == MD_OFF) begin
        mode <= MD_SWON;
        win  <= '0;
      end else if (tick) begin
        if (realign) begin
          mode     <= MD_DATA;
          call_act <= 1'b0;
        end else begin
          case (mode)
            MD_SWON, MD_PRE, MD_FADE: begin
              if (pre_hit && acq) begin
                mode <= MD_PRE;
                win  <= '0;
              end else if ((mode == MD_SWON && win == W_SWON) ||
                           (mode == MD_PRE  && win == W_PRE)  ||
                           (mode == MD_FADE && win == W_FADE)) begin
                mode <= MD_CAROFF;
                win  <= '0;
              end else begin
                win <= win + 1'b1;
              end
            end
            MD_CAROFF: begin
              if (pre_hit && acq) begin
                mode <= MD_PRE;
                win  <= '0;
              end else begin
                win <= (win == W_SCAN) ? '0 : win + 1'b1;
              end
            end
            MD_DATA: begin
              call_act <= call_nx;
              if (uncorr_hit && call_act)                 mode <= MD_FAIL;
              else if (slot_end && !call_act && !sync_hit) mode <= MD_FAIL;
            end
            MD_FAIL: begin
              if (slot_end && !sync_hit) begin
                mode      <= MD_FADE;
                win       <= '0;
                call_act  <= 1'b0;
                call_term <= 1'b1;
              end else begin
                call_act <= call_nx;
                if (slot_end) mode <= MD_DATA;
              end
            end
            default: mode <= MD_OFF;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sacq_ctrl.sv
module sacq_ctrl
  import sacq_pkg::*;
#(
  parameter int CW_BITS      = 32,
  parameter int CW_PER_BATCH = 17,
  parameter int FRAMES       = 8,
  parameter int SWON_BATCHES = 3,
  parameter int PRE_BATCHES  = 1,
  parameter int FADE_BATCHES = 15,
  parameter int FADE_TOL     = 8,
  parameter int SCAN_CW      = 18,
  parameter int LEAD_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              on_pin,
  input  logic              on_reg,
  input  logic              bit_tick,
  input  logic              pre_hit,
  input  logic              sync_hit,
  input  logic              addr_hit,
  input  logic              call_done,
  input  logic              uncorr_hit,
  input  logic [FRAMES-1:0] frame_mask,
  input  logic [LEAD_W-1:0] lead_ticks,
  output logic              rx_en,
  output logic              osc_en,
  output logic [2:0]        mode,
  output logic              call_term
);
  localparam int BATCH_BITS = CW_BITS * CW_PER_BATCH;
  localparam int SCAN_BITS  = CW_BITS * SCAN_CW;
  localparam int SWON_LIM   = SWON_BATCHES * BATCH_BITS;
  localparam int PRE_LIM    = PRE_BATCHES * BATCH_BITS;
  localparam int FADE_LIM   = FADE_BATCHES * BATCH_BITS;
  localparam int MAX_A      = (SWON_LIM > PRE_LIM) ? SWON_LIM : PRE_LIM;
  localparam int MAX_B      = (FADE_LIM > SCAN_BITS) ? FADE_LIM : SCAN_BITS;
  localparam int WIN_MAX    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int LIN_W      = $clog2(BATCH_BITS);
  localparam int WIN_W      = $clog2(WIN_MAX + 1);

  logic             on;
  logic [LIN_W-1:0] lin;
  logic [WIN_W-1:0] win;
  logic             call_act, realign, rx_need, osc_need;
  sacq_mode_e       mode_q;

  assign on = on_pin || on_reg;

  sacq_timebase #(.CW_BITS(CW_BITS), .BATCH_BITS(BATCH_BITS), .LIN_W(LIN_W)) tb_i (
    .clk(clk), .rst(rst), .clr(!on), .tick(bit_tick), .realign(realign), .lin(lin)
  );

  sacq_fsm #(
    .CW_BITS(CW_BITS), .SWON_LIM(SWON_LIM), .PRE_LIM(PRE_LIM), .FADE_LIM(FADE_LIM),
    .SCAN_BITS(SCAN_BITS), .LIN_W(LIN_W), .WIN_W(WIN_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .on(on), .tick(bit_tick), .sync_hit(sync_hit),
    .pre_hit(pre_hit), .addr_hit(addr_hit), .call_done(call_done),
    .uncorr_hit(uncorr_hit), .rx_need(rx_need), .lin(lin), .mode(mode_q),
    .win(win), .call_act(call_act), .call_term(call_term), .realign(realign)
  );

  sacq_window #(
    .CW_BITS(CW_BITS), .CW_PER_BATCH(CW_PER_BATCH), .FRAMES(FRAMES),
    .FADE_TOL(FADE_TOL), .SCAN_BITS(SCAN_BITS), .LIN_W(LIN_W), .WIN_W(WIN_W),
    .LEAD_W(LEAD_W)
  ) win_i (
    .mode(mode_q), .lin(lin), .win(win), .call_act(call_act),
    .frame_mask(frame_mask), .lead(lead_ticks), .rx_need(rx_need), .osc_need(osc_need)
  );

  assign rx_en  = rx_need;
  assign osc_en = osc_need;
  assign mode   = mode_q;
endmodule

// File: rtl/sacq_ctrl_chk.sv
module sacq_ctrl_chk #(
  parameter int CW_BITS = 32,
  parameter int FRAMES  = 8,
  parameter int LEAD_W  = 4,
  parameter int LIN_W   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              on_pin,
  input logic              on_reg,
  input logic [FRAMES-1:0] frame_mask,
  input logic [LEAD_W-1:0] lead_ticks,
  input logic              rx_en,
  input logic              osc_en,
  input logic [2:0]        mode,
  input logic              call_term,
  input logic              call_act,
  input logic [LIN_W-1:0]  lin
);
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (!on_pin && !on_reg) |=> (mode == 3'd0 && !rx_en && !osc_en));

  a_r1_wake: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 && (on_pin || on_reg)) |=> (mode == 3'd1));

  a_r2_swon_rx: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd1) |-> (rx_en && osc_en));

  a_r4_realign: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && $past(mode) != 3'd3 && $past(mode) != 3'd4 && $past(mode) != 3'd0)
      |-> (lin == LIN_W'(CW_BITS)));

  a_r8_term_fade: assert property (@(posedge clk) disable iff (rst)
    call_term |-> (mode == 3'd5 && $past(mode) == 3'd4 && !call_act));

  a_r8_term_single: assert property (@(posedge clk) disable iff (rst)
    call_term |=> !call_term);

  a_r11_lead: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_en) && $stable(mode) && $stable(call_act) && $stable(lead_ticks) &&
     $stable(frame_mask) && lead_ticks != '0) |-> $past(osc_en));

  a_r12_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode != 3'd7);
endmodule

bind sacq_ctrl sacq_ctrl_chk #(
  .CW_BITS(CW_BITS), .FRAMES(FRAMES), .LEAD_W(LEAD_W), .LIN_W(LIN_W)
) chk_i (
  .clk(clk), .rst(rst), .on_pin(on_pin), .on_reg(on_reg), .frame_mask(frame_mask),
  .lead_ticks(lead_ticks), .rx_en(rx_en), .osc_en(osc_en), .mode(mode),
  .call_term(call_term), .call_act(call_act), .lin(lin)
);

// File: tb/sacq_ctrl_tb_top.sv
module sacq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic on_pin = 1'b0, on_reg = 1'b0, bit_tick = 1'b0;
  logic pre_hit = 1'b0, sync_hit = 1'b0, addr_hit = 1'b0, call_done = 1'b0, uncorr_hit = 1'b0;
  logic [7:0] frame_mask = 8'b0000_0100;
  logic [3:0] lead_ticks = 4'd5;
  logic rx_en, osc_en, call_term;
  logic [2:0] mode;

  int checks = 0, errors = 0;
  int m_mode = 0, m_lin = 0, m_win = 0;
  bit m_call = 0, m_term = 0;

  always #4 clk = ~clk;

  sacq_ctrl dut_i (
    .clk(clk), .rst(rst), .on_pin(on_pin), .on_reg(on_reg), .bit_tick(bit_tick),
    .pre_hit(pre_hit), .sync_hit(sync_hit), .addr_hit(addr_hit), .call_done(call_done),
    .uncorr_hit(uncorr_hit), .frame_mask(frame_mask), .lead_ticks(lead_ticks),
    .rx_en(rx_en), .osc_en(osc_en), .mode(mode), .call_term(call_term)
  );

  function automatic bit need(int md, int l, int w, bit call);
    int cw;
    cw = l / 32;
    case (md)
      1, 2: return 1;
      3, 4: return call || cw == 0 || frame_mask[(cw - 1) / 2];
      5:    return l >= 536 || l < 40;
      6:    return w < 32;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int md);
    case (md)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R5";
      4: return "R8";  5: return "R9";  default: return "R10";
    endcase
  endfunction

  // behavioural reference, advanced at the same edge as the design
  always @(posedge clk) begin
    bit rxc, slot, realign, cn;
    int nm;
    if (rst) begin
      m_mode = 0; m_lin = 0; m_win = 0; m_call = 0; m_term = 0;
    end else begin
      m_term = 0;
      if (!(on_pin || on_reg)) begin
        m_mode = 0; m_lin = 0; m_win = 0; m_call = 0;
      end else begin
        rxc = need(m_mode, m_lin, m_win, m_call);
        slot = (m_lin == 31);
        realign = 0;
        nm = m_mode;
        cn = addr_hit ? 1 : (call_done ? 0 : m_call);
        if (m_mode == 0) begin
          nm = 1; m_win = 0;
        end else if (bit_tick) begin
          if ((m_mode == 1 || m_mode == 2 || ((m_mode == 5 || m_mode == 6) && rxc)) && sync_hit) begin
            nm = 3; m_call = 0; realign = 1;
          end else if ((m_mode == 1 || m_mode == 2 || ((m_mode == 5 || m_mode == 6) && rxc)) && pre_hit) begin
            nm = 2; m_win = 0;
          end else begin
            case (m_mode)
              1: if (m_win == 1631) begin nm = 6; m_win = 0; end else m_win++;
              2: if (m_win == 543)  begin nm = 6; m_win = 0; end else m_win++;
              5: if (m_win == 8159) begin nm = 6; m_win = 0; end else m_win++;
              6: m_win = (m_win == 575) ? 0 : m_win + 1;
              3: begin
                if (uncorr_hit && m_call) nm = 4;
                else if (slot && !m_call && !sync_hit) nm = 4;
                m_call = cn;
              end
              4: begin
                if (slot && !sync_hit) begin
                  nm = 5; m_win = 0; m_call = 0; m_term = 1;
                end else begin
                  m_call = cn;
                  if (slot) nm = 3;
                end
              end
              default: ;
            endcase
          end
        end
        if (bit_tick) m_lin = realign ? 32 : (m_lin + 1) % 544;
        m_mode = nm;
      end
    end
  end

  // cycle compare, away from the edge
  always @(posedge clk) begin
    bit erx, eosc;
    #2;
    erx  = need(m_mode, m_lin, m_win, m_call);
    eosc = erx || need(m_mode, (m_lin + lead_ticks) % 544, (m_win + lead_ticks) % 576, m_call);
    checks++;
    if (mode != 3'(m_mode) || rx_en != erx || osc_en != eosc || call_term != m_term) begin
      errors++;
      $display("FAIL %s/R11/R12 cycle compare: mode=%0d rx=%0d osc=%0d term=%0d exp mode=%0d rx=%0d osc=%0d term=%0d",
               tag_of(m_mode), mode, rx_en, osc_en, call_term, m_mode, erx, eosc, m_term);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tk(input bit s, input bit p, input bit a, input bit d, input bit u);
    @(negedge clk);
    bit_tick = 1; sync_hit = s; pre_hit = p; addr_hit = a; call_done = d; uncorr_hit = u;
    @(negedge clk);
    bit_tick = 0; sync_hit = 0; pre_hit = 0; addr_hit = 0; call_done = 0; uncorr_hit = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tk(0, 0, 0, 0, 0);
  endtask

  task automatic goto_lin(input int target);
    for (int i = 0; i < 600 && m_lin != target; i++) tk(0, 0, 0, 0, 0);
  endtask

  task automatic count_stay(input int md, output int n);
    n = 0;
    while (m_mode == md && n < 9000) begin tk(0, 0, 0, 0, 0); n++; end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(mode, 0, "R1 reset mode OFF (R12 code 0)");
    chk(rx_en, 0, "R1 reset rx_en");
    chk(osc_en, 0, "R1 reset osc_en");
    on_reg = 1;
    @(negedge clk);
    chk(mode, 1, "R1 wake to switch-on");
    chk(rx_en, 1, "R2 switch-on rx on");
    idle(100);
    tk(1, 0, 0, 0, 0);
    chk(mode, 3, "R2 sync to data receive");
    idle(127);
    chk(rx_en, 0, "R4 position 159 receiver off");
    chk(osc_en, 1, "R11 oscillator leads frame 2");
    idle(1);
    chk(rx_en, 1, "R4 R5 frame 2 starts at position 160");
    goto_lin(31);
    tk(1, 0, 0, 0, 0);
    chk(mode, 3, "R6 sync hit stays data receive");
    chk(rx_en, 0, "R5 codeword 1 not enabled");
    tk(0, 0, 0, 0, 1);
    chk(mode, 3, "R7 uncorrectable ignored without call");
    goto_lin(540);
    chk(rx_en, 0, "R11 rx off before sync slot");
    chk(osc_en, 1, "R11 osc on before sync slot");
    goto_lin(0);
    chk(rx_en, 1, "R5 sync slot receiver on");
    tk(0, 0, 1, 0, 0);
    goto_lin(40);
    chk(rx_en, 1, "R5 call keeps receiver on");
    goto_lin(31);
    tk(0, 0, 0, 0, 0);
    chk(mode, 3, "R6 sync test skipped during call");
    tk(0, 0, 0, 0, 1);
    chk(mode, 4, "R7 uncorrectable enters data fail");
    goto_lin(31);
    tk(1, 0, 0, 0, 0);
    chk(mode, 3, "R8 sync hit returns to data receive");
    tk(0, 0, 0, 1, 0);
    goto_lin(31);
    tk(0, 0, 0, 0, 0);
    chk(mode, 4, "R6 sync miss enters data fail");
    goto_lin(31);
    tk(0, 0, 0, 0, 0);
    chk(mode, 5, "R8 second miss enters fade recovery");
    chk(call_term, 1, "R8 call_term pulse");
    @(negedge clk);
    chk(call_term, 0, "R8 call_term one clock");
    goto_lin(100);
    chk(rx_en, 0, "R9 outside fade window");
    tk(0, 1, 0, 0, 0);
    chk(mode, 5, "R9 preamble outside window ignored");
    goto_lin(539);
    chk(rx_en, 1, "R9 early side of window");
    tk(1, 0, 0, 0, 0);
    chk(mode, 3, "R9 sync in window to data receive");
    goto_lin(31);
    tk(0, 0, 0, 0, 0);
    goto_lin(31);
    tk(0, 0, 0, 0, 0);
    chk(mode, 5, "R8 back to fade recovery");
    count_stay(5, n);
    chk(n, 8160, "R9 fade timeout ticks");
    chk(mode, 6, "R9 fade timeout to carrier-off");
    chk(rx_en, 1, "R10 scan window open at entry");
    idle(100);
    chk(rx_en, 0, "R10 scan window closed");
    tk(0, 1, 0, 0, 0);
    chk(mode, 6, "R10 preamble outside scan ignored");
    for (int i = 0; i < 600 && m_win != 3; i++) tk(0, 0, 0, 0, 0);
    tk(0, 1, 0, 0, 0);
    chk(mode, 2, "R10 preamble in scan to preamble receive");
    idle(300);
    tk(0, 1, 0, 0, 0);
    count_stay(2, n);
    chk(n, 544, "R3 preamble window restarted");
    chk(mode, 6, "R3 preamble loss to carrier-off");
    tk(1, 0, 0, 0, 0);
    chk(mode, 3, "R10 R4 sync in scan to data receive");
    on_reg = 0;
    @(negedge clk);
    chk(mode, 0, "R1 both controls low gives OFF");
    chk(rx_en, 0, "R1 OFF rx");
    chk(osc_en, 0, "R1 OFF osc");
    on_pin = 1;
    @(negedge clk);
    chk(mode, 1, "R1 pin alone turns ON");
    count_stay(1, n);
    chk(n, 1632, "R2 switch-on timeout ticks");
    chk(mode, 6, "R2 switch-on timeout to carrier-off");
    tk(0, 1, 0, 0, 0);
    chk(mode, 2, "R10 preamble at scan start");
    tk(1, 0, 0, 0, 0);
    chk(mode, 3, "R3 sync in preamble receive");
    chk(mode < 7, 1, "R12 mode code legal");
    idle(10);
    finish_run();
  end
endmodule